// File: doc/BRIEF.md
# Serial Register Port Controller

This block is the slave end of a synchronous serial control link. It gives an external host read and write access to a small bank of configuration registers, and those registers are not all the same width. The host drives a serial clock and a data line. The controller samples both with the system clock, finds the serial clock edges, and frames every transfer on its own. No chip select is involved.

A transfer always opens with an instruction byte. That byte carries a read flag and a register address. The data bytes that follow are exactly as many as the addressed register holds, and the next eight serial clock rising edges then form a new instruction. Two configuration bits in the first register decide how the link behaves:

- **Bit order:** whole word most significant bit first, or least significant bit first with bytes ascending.
- **Pin mode:** one shared bidirectional data pin, or a separate output pin for read data.

Both bits act from the next byte onward, even in the middle of a transfer. A separate asynchronous port reset drops any transfer in flight and leaves the register contents alone.

Top module: `serial_cfg_port`

## Requirements
- R1: An instruction byte is 8 bits. Bit 7 = 1 selects a read and bit 7 = 0 a write. Bits 4:0 give the register address. Bits 6:5 have no effect.
- R2: Input bits are taken on serial clock rising edges. Read data bits change only after serial clock falling edges. The first read bit is presented after the falling edge that follows the last instruction bit.
- R3: A transfer carries 4 data bytes for address 0 (32-bit control register), 3 bytes for address 1 (24-bit control register) and 2 bytes for address 2 (16-bit amplitude register). Every other address takes 1 byte. The next 8 rising edges after the last byte form a new instruction.
- R4: With bit 8 of register 0 clear, the instruction and the data word are shifted most significant bit first. This means the highest byte comes first and each byte goes MSB first.
- R5: With bit 8 of register 0 set, the instruction and each data byte are shifted LSB first. The lowest byte comes first and the bytes then go in ascending order.
- R6: Each written data byte is stored in its register lane once its eighth bit has been taken. The register contents appear on `ctl1_q`, `ctl2_q` and `amp_q`.
- R7: With bit 9 of register 0 clear, read data leaves on `sdio_out` with `sdio_oe` high during the read data phase. `sdio_oe` is low at all other times, and `sdo` stays 0.
- R8: With bit 9 of register 0 set, read data leaves on `sdo` and `sdio_oe` stays low.
- R9: A write that changes bit 8 or bit 9 of register 0 takes effect from the next byte of the same transfer. Each byte's lane is chosen by the bit order in force for that byte.
- R10: Writes to addresses 3 to 31 change no register, and reads from them return zeros.
- R11: `port_rst` high ends any transfer at once and lowers `sdio_oe`. Bytes already stored are kept, and the next 8 rising edges form an instruction.
- R12: `rst_n` low clears all registers to zero and returns the controller to waiting for an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset of registers and controller |
| port_rst | input | 1 | Asynchronous active-high reset of the serial controller only |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data input (shared data pin, input side) |
| sdio_out | output | 1 | Read data toward the shared data pin |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdo | output | 1 | Separate read data output used in 3-wire mode |
| ctl1_q | output | 32 | Contents of register 0 |
| ctl2_q | output | 24 | Contents of register 1 |
| amp_q | output | 16 | Contents of register 2 |

## Verification
If the bit or byte counter drifts, the fault shows up within one transfer. Either a register output takes a byte in the wrong lane, or the following instruction is framed at the wrong edge, and that corrupts every later read. A wrong bit-order or pin-mode decision shows on the very next read bit, either as a wrong level or as data on the wrong pin. A stale output-enable shows within one serial clock period after a read ends or a port reset. The bench restates the framing with its own model and compares every read bit, every enable level and every register value after each byte stream.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int NREG      = 3;
  localparam int ADDR_W    = 5;
  localparam int MAX_BYTES = 4;
  localparam int WORD_W    = MAX_BYTES * 8;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int LANE_W    = $clog2(MAX_BYTES);
  localparam int LSB_BIT   = 8;   // bit order select in register 0
  localparam int WIRE3_BIT = 9;   // pin mode select in register 0

  typedef enum logic {PH_INSTR, PH_DATA} phase_t;

  // byte count of the register at an address; unused addresses take one byte
  function automatic logic [CNT_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(0): return CNT_W'(4);
      ADDR_W'(1): return CNT_W'(3);
      ADDR_W'(2): return CNT_W'(2);
      default:    return CNT_W'(1);
    endcase
  endfunction

  // bit offset of a register in the flattened bank output
  function automatic int reg_offset(input int idx);
    int acc;
    acc = 0;
    for (int i = 0; i < idx; i++) acc += 8 * int'(reg_bytes(ADDR_W'(i)));
    return acc;
  endfunction

  localparam int TOTAL_W = reg_offset(NREG);
  localparam int W_CTL1  = 8 * int'(reg_bytes(ADDR_W'(0)));
  localparam int W_CTL2  = 8 * int'(reg_bytes(ADDR_W'(1)));
  localparam int W_AMP   = 8 * int'(reg_bytes(ADDR_W'(2)));

  // register lane of the n-th byte on the wire
  function automatic logic [LANE_W-1:0] byte_lane(input logic lsb,
                                                  input logic [CNT_W-1:0] idx,
                                                  input logic [CNT_W-1:0] nbytes);
    logic [CNT_W-1:0] t;
    t = lsb ? idx : (nbytes - CNT_W'(1) - idx);
    return t[LANE_W-1:0];
  endfunction

  // bit position inside a byte of the n-th bit on the wire
  function automatic logic [2:0] bit_pos(input logic lsb, input logic [2:0] idx);
    return lsb ? idx : (3'd7 - idx);
  endfunction

  // shift one serial bit into a byte according to bit order
  function automatic logic [7:0] shift_in(input logic lsb, input logic [7:0] cur,
                                          input logic din);
    return lsb ? {din, cur[7:1]} : {cur[6:0], din};
  endfunction
endpackage

// File: rtl/spc_edge_sync.sv
module spc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdio_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din
);
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] dat_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      dat_pipe <= '0;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-1:0], sclk};
      dat_pipe <= {dat_pipe[STAGES-2:0], sdio_in};
    end
  end

  assign sclk_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sclk_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign din       = dat_pipe[STAGES-1];
endmodule

// File: rtl/spc_frame_ctrl.sv
module spc_frame_ctrl
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din,
  input  logic              lsb_first,
  input  logic              rd_bit,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANE_W-1:0] wr_lane,
  output logic [7:0]        wr_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_lane,
  output logic [2:0]        rd_pos,
  output logic              rd_active,
  output logic              out_bit
);
  logic             ctl_rst;
  phase_t           phase;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0] nbytes;
  logic [ADDR_W-1:0] addr;
  logic             is_rd;
  logic [7:0]       shreg;
  logic [7:0]       sh_next;
  logic             byte_done;

  assign ctl_rst   = port_rst | ~rst_n;
  assign sh_next   = shift_in(lsb_first, shreg, din);
  assign byte_done = sclk_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk or posedge ctl_rst) begin
    if (ctl_rst) begin
      phase    <= PH_INSTR;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      nbytes   <= CNT_W'(1);
      addr     <= '0;
      is_rd    <= 1'b0;
      shreg    <= '0;
      out_bit  <= 1'b0;
    end else begin
      if (sclk_rise) begin
        shreg   <= sh_next;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        if (phase == PH_INSTR) begin
          phase    <= PH_DATA;
          is_rd    <= sh_next[7];
          addr     <= sh_next[ADDR_W-1:0];
          nbytes   <= reg_bytes(sh_next[ADDR_W-1:0]);
          byte_cnt <= '0;
        end else begin
          byte_cnt <= byte_cnt + CNT_W'(1);
          if (byte_cnt == nbytes - CNT_W'(1)) phase <= PH_INSTR;
        end
      end
      if (sclk_fall && rd_active) out_bit <= rd_bit;
    end
  end

  assign rd_active = (phase == PH_DATA) && is_rd;
  assign wr_en     = byte_done && (phase == PH_DATA) && !is_rd;
  assign wr_addr   = addr;
  assign wr_byte   = sh_next;
  assign wr_lane   = byte_lane(lsb_first, byte_cnt, nbytes);
  assign rd_addr   = addr;
  assign rd_lane   = byte_lane(lsb_first, byte_cnt, nbytes);
  assign rd_pos    = bit_pos(lsb_first, bit_cnt);

  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (ctl_rst)
    (phase == PH_DATA) |-> (byte_cnt < nbytes)); // R3
  AST_PHASE_ON_RISE: assert property (@(posedge clk) disable iff (ctl_rst)
    !sclk_rise |=> $stable(phase)); // R3
  AST_COUNT_ON_RISE: assert property (@(posedge clk) disable iff (ctl_rst)
    !sclk_rise |=> $stable(bit_cnt)); // R2
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (ctl_rst)
    !sclk_fall |=> $stable(out_bit)); // R2
endmodule

// File: rtl/spc_reg_bank.sv
module spc_reg_bank
  import spc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LANE_W-1:0]  wr_lane,
  input  logic [7:0]         wr_byte,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [LANE_W-1:0]  rd_lane,
  input  logic [2:0]         rd_pos,
  output logic               rd_bit,
  output logic [TOTAL_W-1:0] reg_flat
);
  logic [WORD_W-1:0] padded [NREG];
  logic [WORD_W-1:0] rd_word;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int NB  = int'(reg_bytes(ADDR_W'(g)));
    localparam int OFF = reg_offset(g);
    logic [WORD_W-1:0] word;
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
      if (k < NB) begin : g_used
        logic [7:0] qb;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) qb <= '0;
          else if (wr_en && wr_addr == ADDR_W'(g) && wr_lane == LANE_W'(k)) qb <= wr_byte;
        end
        assign word[k*8 +: 8] = qb;
      end else begin : g_pad
        assign word[k*8 +: 8] = '0;
      end
    end
    assign padded[g] = word;
    assign reg_flat[OFF +: NB*8] = word[NB*8-1:0];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_word = padded[i];
  end

  assign rd_bit = rd_word[{rd_lane, rd_pos}];

  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (CNT_W'(wr_lane) < reg_bytes(wr_addr))); // R9
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo,
  output logic [W_CTL1-1:0] ctl1_q,
  output logic [W_CTL2-1:0] ctl2_q,
  output logic [W_AMP-1:0]  amp_q
);
  logic               sclk_rise, sclk_fall, din;
  logic               wr_en, rd_bit, rd_active, out_bit;
  logic [ADDR_W-1:0]  wr_addr, rd_addr;
  logic [LANE_W-1:0]  wr_lane, rd_lane;
  logic [7:0]         wr_byte;
  logic [2:0]         rd_pos;
  logic [TOTAL_W-1:0] reg_flat;
  logic               lsb_first, three_wire;

  spc_edge_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdio_in(sdio_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din)
  );

  spc_frame_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din),
    .lsb_first(lsb_first), .rd_bit(rd_bit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_byte(wr_byte),
    .rd_addr(rd_addr), .rd_lane(rd_lane), .rd_pos(rd_pos),
    .rd_active(rd_active), .out_bit(out_bit)
  );

  spc_reg_bank i_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_byte(wr_byte),
    .rd_addr(rd_addr), .rd_lane(rd_lane), .rd_pos(rd_pos),
    .rd_bit(rd_bit), .reg_flat(reg_flat)
  );

  assign ctl1_q     = reg_flat[reg_offset(0) +: W_CTL1];
  assign ctl2_q     = reg_flat[reg_offset(1) +: W_CTL2];
  assign amp_q      = reg_flat[reg_offset(2) +: W_AMP];
  assign lsb_first  = ctl1_q[LSB_BIT];
  assign three_wire = ctl1_q[WIRE3_BIT];

  assign sdio_out = out_bit;
  assign sdio_oe  = rd_active & ~three_wire;
  assign sdo      = rd_active & three_wire & out_bit;

  AST_OE_AFTER_RISE: assert property (@(posedge clk) disable iff (port_rst || !rst_n)
    $rose(sdio_oe) |-> $past(sclk_rise)); // R7
  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (port_rst || !rst_n)
    wr_en |-> !sdio_oe); // R1
endmodule

// File: tb/test_serial_cfg_port.sv
`timescale 1ns/1ps
module test_serial_cfg_port;
  localparam int H = 6; // system clocks per serial clock half period

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, port_rst, sclk, sdio_in;
  logic sdio_out, sdio_oe, sdo;
  logic [31:0] ctl1_q;
  logic [23:0] ctl2_q;
  logic [15:0] amp_q;

  serial_cfg_port i_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
    .ctl1_q(ctl1_q), .ctl2_q(ctl2_q), .amp_q(amp_q)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [31:0] m_reg [3];

  function automatic int nbytes_of(input int a);
    if (a == 0) return 4;
    if (a == 1) return 3;
    if (a == 2) return 2;
    return 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_regs(input string req);
    chk(req, ctl1_q, m_reg[0], "ctl1_q");
    chk(req, {8'h00, ctl2_q}, m_reg[1], "ctl2_q");
    chk(req, {16'h0000, amp_q}, m_reg[2], "amp_q");
  endtask

  // one serial bit: data set while clock low, outputs sampled just before the rise
  task automatic put_bit(input logic b, output logic o, output logic oe, output logic sd);
    sdio_in = b;
    wait_clk(H);
    o = sdio_out; oe = sdio_oe; sd = sdo;
    sclk = 1'b1;
    wait_clk(H);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [31:0] wdata, input int stop_bits);
    int a, nb, sent;
    logic rd, lsb0, o, oe, sd;
    a = int'(ins[4:0]); rd = ins[7]; nb = nbytes_of(a); lsb0 = m_reg[0][8]; sent = 0;
    for (int i = 0; i < 8; i++) put_bit(lsb0 ? ins[i] : ins[7-i], o, oe, sd);
    for (int b = 0; b < nb; b++) begin
      logic l, w3;
      int lane;
      l = m_reg[0][8]; w3 = m_reg[0][9];
      lane = l ? b : nb - 1 - b;
      for (int j = 0; j < 8; j++) begin
        int idx;
        logic expb;
        idx = lane * 8 + (l ? j : 7 - j);
        if (sent == stop_bits) return;
        put_bit(rd ? 1'b0 : wdata[idx], o, oe, sd);
        sent++;
        if (rd) begin
          expb = (a < 3) ? m_reg[a][idx] : 1'b0;
          if (w3) begin
            chk("R8", {31'd0, sd}, {31'd0, expb}, "sdo read bit");
            chk("R8", {31'd0, oe}, 32'd0, "sdio_oe in 3-wire read");
          end else begin
            chk("R7", {31'd0, o}, {31'd0, expb}, "sdio_out read bit");
            chk("R7", {31'd0, oe}, 32'd1, "sdio_oe in 2-wire read");
          end
        end else begin
          chk("R7", {31'd0, oe}, 32'd0, "sdio_oe during write");
        end
      end
      if (!rd && a < 3) m_reg[a][lane*8 +: 8] = wdata[lane*8 +: 8];
    end
  endtask

  task automatic idle_pins(input string req);
    wait_clk(H);
    chk(req, {31'd0, sdio_oe}, 32'd0, "sdio_oe idle");
    chk(req, {31'd0, sdo}, 32'd0, "sdo idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) m_reg[i] = '0;
    rst_n = 1'b0; port_rst = 1'b0; sclk = 1'b0; sdio_in = 1'b0;
    wait_clk(4);
    chk_regs("R12");
    chk("R12", {31'd0, sdio_oe}, 32'd0, "sdio_oe in reset");
    rst_n = 1'b1;
    wait_clk(4);

    // R4 R6: MSB-first, 2-wire
    xfer(8'h01, 32'h00A5C3E1, -1);
    xfer(8'h02, 32'h00001234, -1);
    wait_clk(H); chk_regs("R6");
    xfer(8'h81, 32'h0, -1);           // R4 read ctl2
    xfer(8'h82, 32'h0, -1);           // R4 read amp
    idle_pins("R7");
    xfer(8'h00, 32'hDEAD00EF, -1);    // R3 four-byte write
    wait_clk(H); chk_regs("R3");
    xfer(8'hE1, 32'h0, -1);           // R1 bits 6:5 set, still a read of address 1
    xfer(8'h80, 32'h0, -1);           // R3 four-byte read
    xfer(8'h02, 32'h00005AC3, -1);    // R3 back-to-back framing
    wait_clk(H); chk_regs("R3");

    // R8: 3-wire mode
    xfer(8'h00, 32'hDEAD02EF, -1);
    wait_clk(H); chk_regs("R8");
    xfer(8'h81, 32'h0, -1);
    xfer(8'h82, 32'h0, -1);
    idle_pins("R8");

    // R9: bit order switches after byte carrying bit 8; lowest lane never written
    xfer(8'h00, 32'h5A5A0377, -1);
    wait_clk(H); chk_regs("R9");
    chk("R9", {24'd0, ctl1_q[7:0]}, 32'h000000EF, "lane 0 untouched");

    // R5: LSB-first reads and writes in 3-wire mode
    xfer(8'h81, 32'h0, -1);
    xfer(8'h02, 32'h0000BEEF, -1);
    wait_clk(H); chk_regs("R5");
    xfer(8'h82, 32'h0, -1);

    // R5 R7: LSB-first, back to 2-wire
    xfer(8'h00, 32'h00000100, -1);
    wait_clk(H); chk_regs("R5");
    xfer(8'h81, 32'h0, -1);
    xfer(8'h80, 32'h0, -1);

    // R10: unused addresses
    xfer(8'h05, 32'h000000FF, -1);
    wait_clk(H); chk_regs("R10");
    xfer(8'h85, 32'h0, -1);
    xfer(8'h9F, 32'h0, -1);
    xfer(8'h1F, 32'h000000A5, -1);
    wait_clk(H); chk_regs("R10");

    // R11: port reset during a read, then during a write
    xfer(8'h81, 32'h0, 12);
    chk("R11", {31'd0, sdio_oe}, 32'd1, "sdio_oe before port reset");
    port_rst = 1'b1; wait_clk(2);
    chk("R11", {31'd0, sdio_oe}, 32'd0, "sdio_oe during port reset");
    port_rst = 1'b0; wait_clk(2);
    xfer(8'h01, 32'h00112233, 12);
    port_rst = 1'b1; wait_clk(2); port_rst = 1'b0; wait_clk(2);
    chk_regs("R11");
    xfer(8'h02, 32'h00004455, -1);
    wait_clk(H); chk_regs("R11");
    xfer(8'h81, 32'h0, -1);

    // R9 R4: return to MSB-first from LSB-first within one write
    xfer(8'h00, 32'h00000000, -1);
    wait_clk(H); chk_regs("R9");
    xfer(8'h81, 32'h0, -1);
    xfer(8'h82, 32'h0, -1);

    // R12: chip reset clears everything
    rst_n = 1'b0; wait_clk(3);
    for (int i = 0; i < 3; i++) m_reg[i] = '0;
    chk_regs("R12");
    rst_n = 1'b1; wait_clk(3);
    xfer(8'h81, 32'h0, -1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule